// File: doc/BRIEF.md
# SPI Slave Command Decoder

This block is the receive side of an SPI slave port. It runs in mode 0: the master samples on rising SCLK and the block changes MISO after falling SCLK. Every frame opens with an 8-bit command, sent most significant bit first. The block matches the command against four operation codes and then runs the phases that operation needs:

- an address phase of programmable length, for the two buffer operations only;
- an optional dummy phase, with its enable and length set separately for each operation;
- a data phase.

Data moves between the SPI master and one of three places. The first is a 16-word buffer that the host can also read and write. The second is a status word supplied by the host. The third is a status register that keeps the last value written by the master.

The pins SCLK, CS and MOSI are brought into the system clock domain by a short synchronizer, and the block reacts to SCLK edges it detects in that domain. The host sees the following:

- a sticky done flag per operation, plus a common transfer-done flag;
- a mask that gates these flags onto one interrupt line;
- the last decoded operation;
- the current phase.

Top module: `spi_slv_cmd_decoder`

## Requirements
- R1: With `cmd_custom`=0 the operation codes are 0x01 write-status, 0x02 write-buffer, 0x03 read-buffer and 0x04 read-status.
- R2: With `cmd_custom`=1 the operation codes are taken from `cmd_codes`, 8 bits per operation: [7:0] write-status, [15:8] write-buffer, [23:16] read-buffer, [31:24] read-status. The default codes are then no longer recognised, unless they happen to equal a programmed code.
- R3: A command that matches no code is ignored until CS is deasserted. While it is being ignored:
  - `slv_state` reads 6;
  - MISO is driven 0;
  - the done flags, `last_cmd`, the buffer and the stored status do not change.
- R4: Write-buffer reads an address of `wbuf_alen`+1 bits, most significant bit first, and the low 4 bits of that address give the start word A. It then writes `wbuf_dlen`+1 data bits. Data bit n goes to buffer word (A + n/32) mod 16, at bit position 31 − (n mod 32).
- R5: Read-buffer takes an address of `rbuf_alen`+1 bits and `rbuf_dlen`+1 data bits. Each bit is placed on MISO using the same word and bit mapping as R4, and is stable at the rising SCLK edge that samples it.
- R6: When `dummy_en[i]` is set, operation i (0 write-status, 1 write-buffer, 2 read-buffer, 3 read-status) inserts `dummy_len[8i+7:8i]`+1 SCLK cycles before its data phase. The MOSI values in those cycles are ignored.
- R7: Write-status takes `stat_len`+1 bits, most significant bit first. After the last bit it stores them, right-aligned and zero-extended, as the master status.
- R8: Read-status sends bits `stat_len` down to 0, most significant first. The source word is `host_status` when `stat_sel`=0 and the master status when `stat_sel`=1.
- R9: When an operation completes, `int_raw[i]` is set for that operation (index as in R6), and so is `int_raw[4]`. These flags stay set until the matching `int_clr` bit is pulsed. `irq` is the OR of `int_raw & int_en`.
- R10: After a command is decoded, `last_cmd` holds the operation index + 1. `slv_state` reads:
  - 0 while CS is high;
  - 1 during the command;
  - 2 during the address;
  - 3 during the dummy phase;
  - 4 during data;
  - 5 once the operation is complete.
- R11: Deasserting CS at any point returns the block to state 0. An operation cut short this way sets no done flag and leaves the master status unchanged.
- R12: MISO is high-impedance while CS is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sclk | input | 1 | SPI clock from master |
| cs_n | input | 1 | Active-low chip select |
| mosi | input | 1 | Serial data from master |
| miso | output | 1 | Serial data to master, high-Z when deselected |
| cmd_custom | input | 1 | Use programmed command codes |
| cmd_codes | input | 32 | Programmed codes, 8 bits per operation |
| dummy_en | input | 4 | Dummy phase enable per operation |
| dummy_len | input | 32 | Dummy cycles minus one, 8 bits per operation |
| wbuf_alen | input | 6 | Write-buffer address bits minus one |
| rbuf_alen | input | 6 | Read-buffer address bits minus one |
| wbuf_dlen | input | 24 | Write-buffer data bits minus one |
| rbuf_dlen | input | 24 | Read-buffer data bits minus one |
| stat_len | input | 5 | Status bits minus one |
| stat_sel | input | 1 | Read-status source: 0 host word, 1 master status |
| host_status | input | 32 | Status word offered to the master |
| host_we | input | 1 | Host buffer write strobe |
| host_idx | input | 4 | Host buffer word index |
| host_wdata | input | 32 | Host buffer write data |
| host_rdata | output | 32 | Buffer word at host_idx |
| int_en | input | 5 | Interrupt enables |
| int_clr | input | 5 | Done flag clear pulses |
| int_raw | output | 5 | Sticky done flags |
| irq | output | 1 | Interrupt request |
| last_cmd | output | 3 | Last decoded operation |
| slv_state | output | 3 | Current phase |

## Verification
The bench runs directed frames for each of the four operations. It also runs a seeded random series of write-buffer and read-buffer frames, and in that series the following are all randomised:

- the address length and start word;
- whether a dummy phase is present, and its length;
- the data length, including lengths that cross word boundaries and wrap from word 15 to word 0.

Because write-buffer results are read back through the host port and read-buffer results are checked on MISO against a bench model, bit-order errors, word-index errors and phase-length errors each show up on their own. Further directed frames cover:

- an unknown code;
- the two sets of codes, programmed and default;
- a write-status frame cut off part-way;
- read-status from each of its two sources.

Together these separate the decode, abort and source-select paths.

// File: rtl/spi_slv_pkg.sv
package spi_slv_pkg;
   localparam int NUM_OPS = 4;

   typedef enum logic [2:0] {
      ST_IDLE  = 3'd0,
      ST_CMD   = 3'd1,
      ST_ADDR  = 3'd2,
      ST_DUMMY = 3'd3,
      ST_DATA  = 3'd4,
      ST_DONE  = 3'd5,
      ST_SKIP  = 3'd6
   } slv_state_e;

   typedef enum logic [1:0] {
      OP_WSTA = 2'd0,
      OP_WBUF = 2'd1,
      OP_RBUF = 2'd2,
      OP_RSTA = 2'd3
   } slv_op_e;
endpackage

// File: rtl/spi_slv_sync.sv
module spi_slv_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic sclk,
   input  logic cs_n,
   input  logic mosi,
   output logic sclk_rise,
   output logic sclk_fall,
   output logic cs_act,
   output logic mosi_s
);
   logic [STAGES-1:0] s_sclk, s_cs, s_mosi;
   logic              sclk_d;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         s_sclk <= '0;
         s_cs   <= '1;
         s_mosi <= '0;
         sclk_d <= 1'b0;
      end else begin
         s_sclk[0] <= sclk;
         s_cs[0]   <= cs_n;
         s_mosi[0] <= mosi;
         for (int k = 1; k < STAGES; k++) begin
            s_sclk[k] <= s_sclk[k-1];
            s_cs[k]   <= s_cs[k-1];
            s_mosi[k] <= s_mosi[k-1];
         end
         sclk_d <= s_sclk[STAGES-1];
      end
   end

   assign cs_act    = ~s_cs[STAGES-1];
   assign mosi_s    = s_mosi[STAGES-1];
   assign sclk_rise = cs_act &  s_sclk[STAGES-1] & ~sclk_d;
   assign sclk_fall = cs_act & ~s_sclk[STAGES-1] &  sclk_d;
endmodule

// File: rtl/spi_slv_store.sv
module spi_slv_store #(
   parameter int WORDS  = 16,
   parameter int WORD_W = 32,
   localparam int IDX_W = $clog2(WORDS),
   localparam int BIT_W = $clog2(WORD_W)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              spi_we,
   input  logic [IDX_W-1:0]  spi_word,
   input  logic [BIT_W-1:0]  spi_bit,
   input  logic              spi_val,
   input  logic              host_we,
   input  logic [IDX_W-1:0]  host_idx,
   input  logic [WORD_W-1:0] host_wdata,
   output logic [WORD_W-1:0] host_rdata,
   output logic              rd_val
);
   logic [WORD_W-1:0] mem [WORDS];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int w = 0; w < WORDS; w++) mem[w] <= '0;
      end else if (spi_we) begin
         mem[spi_word][spi_bit] <= spi_val;
      end else if (host_we) begin
         mem[host_idx] <= host_wdata;
      end
   end

   assign host_rdata = mem[host_idx];
   assign rd_val     = mem[spi_word][spi_bit];
endmodule

// File: rtl/spi_slv_fsm.sv
module spi_slv_fsm
   import spi_slv_pkg::*;
#(
   parameter int CMD_W  = 8,
   parameter int DUM_W  = 8,
   parameter int ALEN_W = 6,
   parameter int LEN_W  = 24,
   parameter int WORDS  = 16,
   parameter int WORD_W = 32,
   localparam int IDX_W = $clog2(WORDS),
   localparam int BIT_W = $clog2(WORD_W)
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     rise,
   input  logic                     fall,
   input  logic                     cs_act,
   input  logic                     mosi_s,
   input  logic                     cmd_custom,
   input  logic [NUM_OPS*CMD_W-1:0] cmd_codes,
   input  logic [NUM_OPS-1:0]       dummy_en,
   input  logic [NUM_OPS*DUM_W-1:0] dummy_len,
   input  logic [ALEN_W-1:0]        wbuf_alen,
   input  logic [ALEN_W-1:0]        rbuf_alen,
   input  logic [LEN_W-1:0]         wbuf_dlen,
   input  logic [LEN_W-1:0]         rbuf_dlen,
   input  logic [BIT_W-1:0]         stat_len,
   input  logic                     stat_sel,
   input  logic [WORD_W-1:0]        host_status,
   input  logic                     rd_val,
   output logic                     wr_en,
   output logic [IDX_W-1:0]         word_idx,
   output logic [BIT_W-1:0]         bit_idx,
   output logic                     miso_q,
   output logic [NUM_OPS-1:0]       done_set,
   output logic [2:0]               last_cmd,
   output slv_state_e               st
);
   slv_op_e           op, hit_op;
   logic [LEN_W-1:0]  cnt, cur_len;
   logic [CMD_W-1:0]  csh, rx_cmd;
   logic [IDX_W-1:0]  addr_q;
   logic [WORD_W-1:0] ssh, mstat, stat_src;
   logic [ALEN_W-1:0] cur_alen;
   logic [DUM_W-1:0]  cur_dlen;
   logic [NUM_OPS-1:0] hit;
   logic              out_bit;

   assign rx_cmd = {csh[CMD_W-2:0], mosi_s};

   for (genvar i = 0; i < NUM_OPS; i++) begin : g_match
      logic [CMD_W-1:0] code;
      assign code   = cmd_custom ? cmd_codes[i*CMD_W +: CMD_W] : CMD_W'(i + 1);
      assign hit[i] = (rx_cmd == code);
   end

   always_comb begin
      hit_op = OP_WSTA;
      for (int i = NUM_OPS - 1; i >= 0; i--)
         if (hit[i]) hit_op = slv_op_e'(2'(i));
   end

   assign cur_alen = (op == OP_WBUF) ? wbuf_alen : rbuf_alen;
   assign cur_dlen = dummy_len[int'(op)*DUM_W +: DUM_W];

   always_comb begin
      case (op)
         OP_WBUF: cur_len = wbuf_dlen;
         OP_RBUF: cur_len = rbuf_dlen;
         default: cur_len = LEN_W'(stat_len);
      endcase
   end

   assign word_idx = addr_q + cnt[BIT_W +: IDX_W];
   assign bit_idx  = ~cnt[BIT_W-1:0];
   assign wr_en    = rise && (st == ST_DATA) && (op == OP_WBUF);
   assign stat_src = stat_sel ? mstat : host_status;
   assign out_bit  = (op == OP_RSTA) ? stat_src[stat_len - cnt[BIT_W-1:0]]
                   : (op == OP_RBUF) ? rd_val : 1'b0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st       <= ST_IDLE;
         op       <= OP_WSTA;
         cnt      <= '0;
         csh      <= '0;
         addr_q   <= '0;
         ssh      <= '0;
         mstat    <= '0;
         last_cmd <= '0;
         done_set <= '0;
         miso_q   <= 1'b0;
      end else begin
         done_set <= '0;
         if (!cs_act) begin
            st     <= ST_IDLE;
            cnt    <= '0;
            miso_q <= 1'b0;
         end else begin
            if (fall) miso_q <= (st == ST_DATA) ? out_bit : 1'b0;
            case (st)
               ST_IDLE: begin
                  st  <= ST_CMD;
                  cnt <= '0;
                  csh <= '0;
               end
               ST_CMD: if (rise) begin
                  csh <= rx_cmd;
                  if (cnt == LEN_W'(CMD_W - 1)) begin
                     cnt <= '0;
                     ssh <= '0;
                     if (|hit) begin
                        op       <= hit_op;
                        last_cmd <= 3'(hit_op) + 3'd1;
                        if (hit_op == OP_WBUF || hit_op == OP_RBUF) st <= ST_ADDR;
                        else st <= dummy_en[hit_op] ? ST_DUMMY : ST_DATA;
                     end else begin
                        st <= ST_SKIP;
                     end
                  end else begin
                     cnt <= cnt + LEN_W'(1);
                  end
               end
               ST_ADDR: if (rise) begin
                  addr_q <= {addr_q[IDX_W-2:0], mosi_s};
                  if (cnt == LEN_W'(cur_alen)) begin
                     cnt <= '0;
                     st  <= dummy_en[op] ? ST_DUMMY : ST_DATA;
                  end else begin
                     cnt <= cnt + LEN_W'(1);
                  end
               end
               ST_DUMMY: if (rise) begin
                  if (cnt == LEN_W'(cur_dlen)) begin
                     cnt <= '0;
                     st  <= ST_DATA;
                  end else begin
                     cnt <= cnt + LEN_W'(1);
                  end
               end
               ST_DATA: if (rise) begin
                  ssh <= {ssh[WORD_W-2:0], mosi_s};
                  if (cnt == cur_len) begin
                     st           <= ST_DONE;
                     done_set[op] <= 1'b1;
                     if (op == OP_WSTA) mstat <= {ssh[WORD_W-2:0], mosi_s};
                  end else begin
                     cnt <= cnt + LEN_W'(1);
                  end
               end
               default: ;
            endcase
         end
      end
   end

   AST_ABORT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !cs_act |=> st == ST_IDLE); // R11
   AST_SKIP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_SKIP && cs_act) |=> st == ST_SKIP); // R3
   AST_DONE_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
      st == ST_DONE |-> ($past(st) == ST_DATA || $past(st) == ST_DONE)); // R9
   AST_MSTAT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      st != ST_DATA |=> $stable(mstat)); // R7
   AST_LASTCMD_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      last_cmd <= 3'd4); // R10
endmodule

// File: rtl/spi_slv_cmd_decoder.sv
module spi_slv_cmd_decoder
   import spi_slv_pkg::*;
#(
   parameter int CMD_W   = 8,
   parameter int DUM_W   = 8,
   parameter int ALEN_W  = 6,
   parameter int LEN_W   = 24,
   parameter int WORDS   = 16,
   parameter int WORD_W  = 32,
   parameter int SYNC_ST = 2,
   localparam int IDX_W  = $clog2(WORDS),
   localparam int BIT_W  = $clog2(WORD_W),
   localparam int IRQ_W  = NUM_OPS + 1
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     sclk,
   input  logic                     cs_n,
   input  logic                     mosi,
   output logic                     miso,
   input  logic                     cmd_custom,
   input  logic [NUM_OPS*CMD_W-1:0] cmd_codes,
   input  logic [NUM_OPS-1:0]       dummy_en,
   input  logic [NUM_OPS*DUM_W-1:0] dummy_len,
   input  logic [ALEN_W-1:0]        wbuf_alen,
   input  logic [ALEN_W-1:0]        rbuf_alen,
   input  logic [LEN_W-1:0]         wbuf_dlen,
   input  logic [LEN_W-1:0]         rbuf_dlen,
   input  logic [BIT_W-1:0]         stat_len,
   input  logic                     stat_sel,
   input  logic [WORD_W-1:0]        host_status,
   input  logic                     host_we,
   input  logic [IDX_W-1:0]         host_idx,
   input  logic [WORD_W-1:0]        host_wdata,
   output logic [WORD_W-1:0]        host_rdata,
   input  logic [IRQ_W-1:0]         int_en,
   input  logic [IRQ_W-1:0]         int_clr,
   output logic [IRQ_W-1:0]         int_raw,
   output logic                     irq,
   output logic [2:0]               last_cmd,
   output logic [2:0]               slv_state
);
   logic               rise, fall, cs_act, mosi_s, miso_q;
   logic               wr_en, rd_val;
   logic [IDX_W-1:0]   word_idx;
   logic [BIT_W-1:0]   bit_idx;
   logic [NUM_OPS-1:0] done_set;
   slv_state_e         st;

   spi_slv_sync #(.STAGES(SYNC_ST)) u_sync (
      .clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n), .mosi(mosi),
      .sclk_rise(rise), .sclk_fall(fall), .cs_act(cs_act), .mosi_s(mosi_s));

   spi_slv_fsm #(
      .CMD_W(CMD_W), .DUM_W(DUM_W), .ALEN_W(ALEN_W), .LEN_W(LEN_W),
      .WORDS(WORDS), .WORD_W(WORD_W)
   ) u_fsm (
      .clk(clk), .rst_n(rst_n), .rise(rise), .fall(fall), .cs_act(cs_act),
      .mosi_s(mosi_s), .cmd_custom(cmd_custom), .cmd_codes(cmd_codes),
      .dummy_en(dummy_en), .dummy_len(dummy_len), .wbuf_alen(wbuf_alen),
      .rbuf_alen(rbuf_alen), .wbuf_dlen(wbuf_dlen), .rbuf_dlen(rbuf_dlen),
      .stat_len(stat_len), .stat_sel(stat_sel), .host_status(host_status),
      .rd_val(rd_val), .wr_en(wr_en), .word_idx(word_idx), .bit_idx(bit_idx),
      .miso_q(miso_q), .done_set(done_set), .last_cmd(last_cmd), .st(st));

   spi_slv_store #(.WORDS(WORDS), .WORD_W(WORD_W)) u_store (
      .clk(clk), .rst_n(rst_n), .spi_we(wr_en), .spi_word(word_idx),
      .spi_bit(bit_idx), .spi_val(mosi_s), .host_we(host_we),
      .host_idx(host_idx), .host_wdata(host_wdata), .host_rdata(host_rdata),
      .rd_val(rd_val));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) int_raw <= '0;
      else        int_raw <= (int_raw & ~int_clr) | {|done_set, done_set};
   end

   assign irq       = |(int_raw & int_en);
   assign miso      = cs_act ? miso_q : 1'bz;
   assign slv_state = 3'(st);

   AST_TRANS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      |done_set |=> int_raw[NUM_OPS]); // R9
   AST_RAW_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (int_raw[NUM_OPS] && !int_clr[NUM_OPS]) |=> int_raw[NUM_OPS]); // R9
endmodule

// File: tb/tb_spi_slv_cmd_decoder.sv
module tb_spi_slv_cmd_decoder;
   logic clk = 0, rst_n = 0, sclk = 0, cs_n = 1, mosi = 0;
   wire  miso;
   logic        cmd_custom = 0;
   logic [31:0] cmd_codes = '0;
   logic [3:0]  dummy_en = '0;
   logic [31:0] dummy_len = '0;
   logic [5:0]  wbuf_alen = 0, rbuf_alen = 0;
   logic [23:0] wbuf_dlen = 0, rbuf_dlen = 0;
   logic [4:0]  stat_len = 0;
   logic        stat_sel = 0;
   logic [31:0] host_status = 0;
   logic        host_we = 0;
   logic [3:0]  host_idx = 0;
   logic [31:0] host_wdata = 0;
   wire  [31:0] host_rdata;
   logic [4:0]  int_en = 0, int_clr = 0;
   wire  [4:0]  int_raw;
   wire         irq;
   wire  [2:0]  last_cmd, slv_state;

   int checks = 0, errors = 0;
   logic [31:0] mem_m [16];
   logic tx_b [512];
   logic rx_b [512];

   always #2.5 clk = ~clk;

   spi_slv_cmd_decoder dut (.*);

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic sbit(input logic b, output logic r);
      @(negedge clk) mosi = b;
      repeat (8) @(negedge clk);
      r = miso;
      sclk = 1;
      repeat (8) @(negedge clk);
      sclk = 0;
   endtask

   task automatic close_cs();
      repeat (4) @(negedge clk);
      cs_n = 1;
      repeat (10) @(negedge clk);
   endtask

   task automatic frame(input logic [7:0] code, input int abits, input logic [63:0] aval,
                        input int dcyc, input int nbits, input bit keep_open);
      logic r;
      @(negedge clk) cs_n = 0;
      repeat (8) @(negedge clk);
      for (int i = 7; i >= 0; i--) sbit(code[i], r);
      for (int i = abits - 1; i >= 0; i--) sbit(aval[i], r);
      for (int i = 0; i < dcyc; i++) sbit(1'($urandom), r);
      for (int i = 0; i < nbits; i++) begin
         sbit(tx_b[i], r);
         rx_b[i] = r;
      end
      if (!keep_open) close_cs();
   endtask

   task automatic verify_mem(input string req);
      for (int w = 0; w < 16; w++) begin
         @(negedge clk) host_idx = 4'(w);
         #1 chk(req, host_rdata, mem_m[w]);
      end
   endtask

   task automatic host_write(input int w, input logic [31:0] d);
      @(negedge clk) begin host_we = 1; host_idx = 4'(w); host_wdata = d; end
      @(negedge clk) host_we = 0;
      mem_m[w] = d;
   endtask

   task automatic clear_flags();
      @(negedge clk) int_clr = '1;
      @(negedge clk) int_clr = '0;
   endtask

   function automatic logic model_bit(input logic [3:0] a, input int n);
      return mem_m[4'(a + 4'(n / 32))][31 - (n % 32)];
   endfunction

   // bit n of the data phase, mapped into the buffer model (R4/R5)
   task automatic apply_wbuf(input logic [3:0] a, input int n);
      for (int i = 0; i < n; i++) mem_m[4'(a + 4'(i / 32))][31 - (i % 32)] = tx_b[i];
   endtask

   function automatic int rbuf_mism(input logic [3:0] a, input int n);
      int m = 0;
      for (int i = 0; i < n; i++) if (rx_b[i] !== model_bit(a, i)) m++;
      return m;
   endfunction

   function automatic logic [31:0] rx_word(input int n);
      logic [31:0] v = 0;
      for (int i = 0; i < n; i++) v = {v[30:0], rx_b[i]};
      return v;
   endfunction

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      logic [31:0] v, vs;
      logic [4:0]  raw_before;
      logic [2:0]  lc_before;
      int n, ab, dc;
      logic [63:0] av;
      void'($urandom(32'd1234));
      for (int w = 0; w < 16; w++) mem_m[w] = 0;
      repeat (5) @(negedge clk);
      rst_n = 1;
      repeat (3) @(negedge clk);

      // reset state
      chk("R12 reset miso z", {63'b0, miso === 1'bz}, 1);
      chk("R10 reset state", slv_state, 0);
      chk("R10 reset last_cmd", last_cmd, 0);
      chk("R9 reset raw", int_raw, 0);
      chk("R9 reset irq", irq, 0);

      // R1 R4: default write-buffer, 4-bit address 5, 40 bits
      int_en = 5'b00010;
      wbuf_alen = 3; wbuf_dlen = 39;
      for (int i = 0; i < 40; i++) tx_b[i] = 1'($urandom);
      frame(8'h02, 4, 64'd5, 0, 40, 1);
      chk("R10 done state", slv_state, 5);
      close_cs();
      apply_wbuf(4'd5, 40);
      verify_mem("R4 wbuf");
      chk("R1 last_cmd wbuf", last_cmd, 2);
      chk("R9 wbuf flags", int_raw, 5'b10010);
      chk("R9 irq on", irq, 1);
      clear_flags();
      chk("R9 cleared", int_raw, 0);
      chk("R9 irq off", irq, 0);
      chk("R12 idle miso z", {63'b0, miso === 1'bz}, 1);

      // R5 R6: read-buffer wrapping 15->0, 6-bit address, 3 dummy cycles
      host_write(15, $urandom); host_write(0, $urandom);
      rbuf_alen = 5; rbuf_dlen = 47;
      dummy_en = 4'b0100; dummy_len = 32'h0002_0000;
      frame(8'h03, 6, 64'h2F, 3, 48, 0);
      chk("R5 R6 rbuf wrap bits", rbuf_mism(4'hF, 48), 0);
      chk("R1 last_cmd rbuf", last_cmd, 3);
      chk("R9 rbuf flags", int_raw, 5'b10100);
      clear_flags();

      // R7: write-status 12 bits
      stat_len = 11; v = 32'($urandom) & 32'hFFF;
      for (int i = 0; i < 12; i++) tx_b[i] = v[11 - i];
      frame(8'h01, 0, 0, 0, 12, 0);
      chk("R1 last_cmd wsta", last_cmd, 1);
      chk("R9 wsta flags", int_raw, 5'b10001);
      clear_flags();
      // R8 R6: read back master status with 2 dummy cycles
      stat_sel = 1; dummy_en = 4'b1000; dummy_len = 32'h0100_0000;
      frame(8'h04, 0, 0, 2, 12, 0);
      chk("R7 R8 master status", rx_word(12), v);
      chk("R9 rsta flags", int_raw, 5'b11000);
      clear_flags();

      // R11: cut-short write-status keeps old value, sets no flag
      for (int i = 0; i < 12; i++) tx_b[i] = ~v[11 - i];
      frame(8'h01, 0, 0, 0, 5, 1);
      chk("R10 data state", slv_state, 4);
      close_cs();
      chk("R11 idle after abort", slv_state, 0);
      chk("R11 no flag", int_raw, 0);
      dummy_en = 0;
      frame(8'h04, 0, 0, 0, 12, 0);
      chk("R11 status kept", rx_word(12), v);
      clear_flags();

      // R8: host status source, full 32 bits
      stat_sel = 0; stat_len = 31; host_status = $urandom;
      frame(8'h04, 0, 0, 0, 32, 0);
      chk("R8 host status", rx_word(32), host_status);
      clear_flags();

      // R3: unknown code ignored
      raw_before = int_raw; lc_before = last_cmd;
      for (int i = 0; i < 24; i++) tx_b[i] = 1'($urandom);
      frame(8'hA5, 0, 0, 0, 24, 1);
      chk("R3 skip state", slv_state, 6);
      chk("R3 miso low", rx_word(24), 0);
      close_cs();
      chk("R3 flags unchanged", int_raw, raw_before);
      chk("R3 last_cmd unchanged", last_cmd, lc_before);
      verify_mem("R3 buffer unchanged");

      // R2: programmed codes
      cmd_custom = 1; cmd_codes = 32'h9483_7261;
      wbuf_alen = 3; wbuf_dlen = 15;
      for (int i = 0; i < 16; i++) tx_b[i] = 1'($urandom);
      frame(8'h72, 4, 64'd9, 0, 16, 0);
      apply_wbuf(4'd9, 16);
      verify_mem("R2 custom wbuf");
      chk("R2 last_cmd", last_cmd, 2);
      clear_flags();
      frame(8'h02, 4, 64'd9, 0, 16, 1);
      chk("R2 default code rejected", slv_state, 6);
      close_cs();
      chk("R2 no flag", int_raw, 0);
      cmd_custom = 0;

      // random buffer traffic (R4 R5 R6)
      for (int it = 0; it < 14; it++) begin
         ab = 4 + ($urandom % 6);
         av = {$urandom, $urandom};
         n  = 1 + ($urandom % 80);
         dc = ($urandom % 2) ? 1 + ($urandom % 4) : 0;
         dummy_en  = (dc != 0) ? 4'b0110 : 4'b0000;
         dummy_len = {8'h00, 8'(dc - 1), 8'(dc - 1), 8'h00};
         if ($urandom % 2) begin
            wbuf_alen = 6'(ab - 1); wbuf_dlen = 24'(n - 1);
            for (int i = 0; i < n; i++) tx_b[i] = 1'($urandom);
            frame(8'h02, ab, av, dc, n, 0);
            apply_wbuf(av[3:0], n);
            verify_mem("R4 random wbuf");
         end else begin
            host_write($urandom % 16, $urandom);
            rbuf_alen = 6'(ab - 1); rbuf_dlen = 24'(n - 1);
            frame(8'h03, ab, av, dc, n, 0);
            chk("R5 random rbuf", rbuf_mism(av[3:0], n), 0);
         end
      end

      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule